// File: doc/BRIEF.md
# ALU Operand Forwarding Selector

This block steers the two ALU operands of the execute stage in a five-stage pipeline. It looks at the two source register IDs held in the ID/EX stage register. It compares each of them with the destination IDs of the two instructions ahead: the one in EX/MEM and the one in MEM/WB. When an older instruction is about to write a register that the executing instruction reads, that operand is taken from the later stage instead of the stale copy read in decode.

For each operand the block gives a 2-bit select and also applies it in a small operand multiplexer. The candidates are the ID/EX register value, the prior ALU result in EX/MEM, and the writeback value in MEM/WB. The MEM/WB value may be loaded memory data or an older ALU result. The select encoding is 00 for ID/EX, 01 for EX/MEM and 10 for MEM/WB; 11 is reserved.

The block holds no state. Every output is a combinational function of the current stage register contents, so it needs no clock or reset. The pipeline registers around it provide the timing. No valid/ready handshake is used, because the block does no buffering and produces its answer in the same cycle the stage registers present their contents.

Top module: `alu_fwd_sel`

## Requirements
- R1: When neither later stage matches a source, that operand's select is 00 and the operand equals its ID/EX value.
- R2: When EX/MEM has its write enable set, a nonzero destination ID and a destination equal to a source, that operand's select is 01 and the operand equals the EX/MEM ALU result.
- R3: When only MEM/WB meets the same rule (write enable set, nonzero destination, equal to the source), that operand's select is 10 and the operand equals the MEM/WB writeback value.
- R4: When both EX/MEM and MEM/WB qualify for the same source, the select is 01, so the newer EX/MEM value wins.
- R5: A destination ID of 0 never causes forwarding from either stage, even with its write enable set and a source of 0.
- R6: A stage whose write enable is low never causes forwarding, even when its destination matches the source.
- R7: Operands A and B are decided independently. Each may forward from a different stage, or both may forward from the same stage.
- R8: The select outputs never carry the reserved code 11. If the operand multiplexer receives 11, it passes the ID/EX value.
- R9: Selects and operands follow the inputs within the same cycle, with no clocked delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_id | input | 5 | First source register ID from ID/EX |
| src_b_id | input | 5 | Second source register ID from ID/EX |
| exm_wr_en | input | 1 | EX/MEM register-write enable |
| exm_dst_id | input | 5 | EX/MEM destination register ID |
| mwb_wr_en | input | 1 | MEM/WB register-write enable |
| mwb_dst_id | input | 5 | MEM/WB destination register ID |
| idex_a_val | input | 32 | First operand value read in decode |
| idex_b_val | input | 32 | Second operand value read in decode |
| exm_alu_val | input | 32 | Prior ALU result held in EX/MEM |
| mwb_wb_val | input | 32 | Writeback value held in MEM/WB |
| sel_a | output | 2 | Select for operand A (00 ID/EX, 01 EX/MEM, 10 MEM/WB) |
| sel_b | output | 2 | Select for operand B, same encoding |
| opnd_a | output | 32 | Operand A after forwarding |
| opnd_b | output | 32 | Operand B after forwarding |

## Verification
The bench applies the following input patterns, each of which tells a different case apart:
- A back-to-back dependence on both operands distinguishes a correct EX/MEM forward from a stale ID/EX read.
- A dependence two instructions apart isolates the MEM/WB path.
- Both stages writing the same register shows whether the newer producer wins.
- Writes to register 0, and matches with the write enable low, show that the block forwards nothing when no real producer exists.
- Split cases, where A forwards from one stage and B from the other, reveal any crossed or shared select logic.
- A long run of random IDs drawn from a small register range makes matches frequent and confirms that the reserved code never appears.

// File: rtl/alu_fwd_pkg.sv
package alu_fwd_pkg;

  typedef enum logic [1:0] {
    SEL_IDEX = 2'b00,
    SEL_EXM  = 2'b01,
    SEL_MWB  = 2'b10,
    SEL_RSVD = 2'b11
  } fwd_sel_e;

  localparam int NUM_OPND  = 2;
  localparam int NUM_STAGE = 2;

endpackage

// File: rtl/alu_fwd_match.sv
module alu_fwd_match #(
  parameter int ID_W = 5
) (
  input  logic [ID_W-1:0] src_id,
  input  logic [ID_W-1:0] dst_id,
  input  logic            wr_en,
  output logic            hit
);

  logic dst_nonzero;
  logic id_equal;

  always_comb begin
    dst_nonzero = |dst_id;
    id_equal    = (dst_id == src_id);
    hit         = wr_en && dst_nonzero && id_equal;
  end

endmodule

// File: rtl/alu_fwd_pick.sv
module alu_fwd_pick
  import alu_fwd_pkg::*;
#(
  parameter int ID_W = 5
) (
  input  logic            hit_exm,
  input  logic            hit_mwb,
  input  logic [ID_W-1:0] exm_dst_id,
  input  logic [ID_W-1:0] mwb_dst_id,
  input  logic            exm_wr_en,
  input  logic            mwb_wr_en,
  output fwd_sel_e        sel
);

  always_comb begin
    if (hit_exm)      sel = SEL_EXM;
    else if (hit_mwb) sel = SEL_MWB;
    else              sel = SEL_IDEX;
  end

  // R5: register 0 is never a producer
  always_comb begin
    if (exm_dst_id == '0)
      assert_exm_zero_dst_R5: assert (!hit_exm) else $error("EX/MEM zero destination flagged");
    if (mwb_dst_id == '0)
      assert_mwb_zero_dst_R5: assert (!hit_mwb) else $error("MEM/WB zero destination flagged");
  end

  // R6: a stage that does not write never forwards
  always_comb begin
    if (!exm_wr_en)
      assert_exm_wr_off_R6: assert (!hit_exm) else $error("EX/MEM hit without write enable");
    if (!mwb_wr_en)
      assert_mwb_wr_off_R6: assert (!hit_mwb) else $error("MEM/WB hit without write enable");
  end

endmodule

// File: rtl/alu_fwd_opnd_mux.sv
module alu_fwd_opnd_mux
  import alu_fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] idex_val,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] mwb_val,
  output logic [DATA_W-1:0] opnd
);

  always_comb begin
    unique case (sel)
      SEL_EXM:  opnd = exm_val;
      SEL_MWB:  opnd = mwb_val;
      SEL_IDEX: opnd = idex_val;
      default:  opnd = idex_val;
    endcase
  end

  // R8: the selector feeding this mux never uses the reserved code
  always_comb begin
    assert_sel_legal_R8: assert (sel != SEL_RSVD) else $error("reserved select code seen");
  end

endmodule

// File: rtl/alu_fwd_sel.sv
module alu_fwd_sel
  import alu_fwd_pkg::*;
#(
  parameter int ID_W   = 5,
  parameter int DATA_W = 32
) (
  input  logic [ID_W-1:0]   src_a_id,
  input  logic [ID_W-1:0]   src_b_id,
  input  logic              exm_wr_en,
  input  logic [ID_W-1:0]   exm_dst_id,
  input  logic              mwb_wr_en,
  input  logic [ID_W-1:0]   mwb_dst_id,
  input  logic [DATA_W-1:0] idex_a_val,
  input  logic [DATA_W-1:0] idex_b_val,
  input  logic [DATA_W-1:0] exm_alu_val,
  input  logic [DATA_W-1:0] mwb_wb_val,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  logic [ID_W-1:0]   src_id   [NUM_OPND];
  logic [DATA_W-1:0] idex_val [NUM_OPND];
  logic [DATA_W-1:0] opnd     [NUM_OPND];
  fwd_sel_e          sel      [NUM_OPND];
  logic              hit_exm  [NUM_OPND];
  logic              hit_mwb  [NUM_OPND];

  always_comb begin
    src_id[0]   = src_a_id;
    src_id[1]   = src_b_id;
    idex_val[0] = idex_a_val;
    idex_val[1] = idex_b_val;
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    alu_fwd_match #(.ID_W(ID_W)) i_match_exm (
      .src_id (src_id[g]),
      .dst_id (exm_dst_id),
      .wr_en  (exm_wr_en),
      .hit    (hit_exm[g])
    );

    alu_fwd_match #(.ID_W(ID_W)) i_match_mwb (
      .src_id (src_id[g]),
      .dst_id (mwb_dst_id),
      .wr_en  (mwb_wr_en),
      .hit    (hit_mwb[g])
    );

    alu_fwd_pick #(.ID_W(ID_W)) i_pick (
      .hit_exm    (hit_exm[g]),
      .hit_mwb    (hit_mwb[g]),
      .exm_dst_id (exm_dst_id),
      .mwb_dst_id (mwb_dst_id),
      .exm_wr_en  (exm_wr_en),
      .mwb_wr_en  (mwb_wr_en),
      .sel        (sel[g])
    );

    alu_fwd_opnd_mux #(.DATA_W(DATA_W)) i_mux (
      .sel      (sel[g]),
      .idex_val (idex_val[g]),
      .exm_val  (exm_alu_val),
      .mwb_val  (mwb_wb_val),
      .opnd     (opnd[g])
    );
  end

  always_comb begin
    sel_a  = sel[0];
    sel_b  = sel[1];
    opnd_a = opnd[0];
    opnd_b = opnd[1];
  end

  // R2 and R4: an EX/MEM producer wins for operand A, and its value is used
  always_comb begin
    if (exm_wr_en && (exm_dst_id != '0) && (exm_dst_id == src_a_id)) begin
      assert_exm_fwd_a_R2: assert (sel_a == 2'b01 && opnd_a == exm_alu_val)
        else $error("operand A missed EX/MEM forward");
    end
  end

  // R3: MEM/WB forwarding on operand B when EX/MEM does not qualify
  always_comb begin
    if (mwb_wr_en && (mwb_dst_id != '0) && (mwb_dst_id == src_b_id) &&
        !(exm_wr_en && (exm_dst_id != '0) && (exm_dst_id == src_b_id))) begin
      assert_mwb_fwd_b_R3: assert (sel_b == 2'b10 && opnd_b == mwb_wb_val)
        else $error("operand B missed MEM/WB forward");
    end
  end

  // R1: no qualifying producer means the decode value passes through
  always_comb begin
    if (!(exm_wr_en && (exm_dst_id != '0) && (exm_dst_id == src_a_id)) &&
        !(mwb_wr_en && (mwb_dst_id != '0) && (mwb_dst_id == src_a_id))) begin
      assert_no_fwd_a_R1: assert (sel_a == 2'b00 && opnd_a == idex_a_val)
        else $error("operand A forwarded without producer");
    end
  end

endmodule

// File: tb/test_alu_fwd_sel.sv
`timescale 1ns/1ps
module test_alu_fwd_sel;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [4:0]  src_a_id, src_b_id, exm_dst_id, mwb_dst_id;
  logic        exm_wr_en, mwb_wr_en;
  logic [31:0] idex_a_val, idex_b_val, exm_alu_val, mwb_wb_val;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  alu_fwd_sel i_alu_fwd_sel (
    .src_a_id(src_a_id), .src_b_id(src_b_id),
    .exm_wr_en(exm_wr_en), .exm_dst_id(exm_dst_id),
    .mwb_wr_en(mwb_wr_en), .mwb_dst_id(mwb_dst_id),
    .idex_a_val(idex_a_val), .idex_b_val(idex_b_val),
    .exm_alu_val(exm_alu_val), .mwb_wb_val(mwb_wb_val),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  typedef struct {
    logic [1:0]  sa, sb;
    logic [31:0] oa, ob;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  function automatic logic [1:0] want_sel(logic [4:0] src);
    if (exm_wr_en && exm_dst_id != 0 && exm_dst_id == src) return 2'b01;
    if (mwb_wr_en && mwb_dst_id != 0 && mwb_dst_id == src) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] want_val(logic [1:0] s, logic [31:0] idv);
    if (s == 2'b01) return exm_alu_val;
    if (s == 2'b10) return mwb_wb_val;
    return idv;
  endfunction

  task automatic drive(input string tag,
                       input logic [4:0] sa, input logic [4:0] sb,
                       input logic ewe, input logic [4:0] ed,
                       input logic mwe, input logic [4:0] md);
    exp_t e;
    @(posedge clk);
    src_a_id = sa; src_b_id = sb;
    exm_wr_en = ewe; exm_dst_id = ed;
    mwb_wr_en = mwe; mwb_dst_id = md;
    idex_a_val  = $urandom;
    idex_b_val  = $urandom;
    exm_alu_val = $urandom;
    mwb_wb_val  = $urandom;
    e.sa  = want_sel(sa);
    e.sb  = want_sel(sb);
    e.oa  = want_val(e.sa, idex_a_val);
    e.ob  = want_val(e.sb, idex_b_val);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: outputs settle within the cycle (R9), sampled at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "sel_a", {30'd0, sel_a}, {30'd0, e.sa});
      check(e.tag, "sel_b", {30'd0, sel_b}, {30'd0, e.sb});
      check(e.tag, "opnd_a", opnd_a, e.oa);
      check(e.tag, "opnd_b", opnd_b, e.ob);
      check("R8", "sel_a_legal", {31'd0, sel_a == 2'b11}, 32'd0);
      check("R8", "sel_b_legal", {31'd0, sel_b == 2'b11}, 32'd0);
    end
  end

  initial begin
    src_a_id = 0; src_b_id = 0; exm_wr_en = 0; exm_dst_id = 0;
    mwb_wr_en = 0; mwb_dst_id = 0; idex_a_val = 0; idex_b_val = 0;
    exm_alu_val = 0; mwb_wb_val = 0;
    drive("R1_reset", 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive("R1", 5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd8);
    drive("R2_R7_back2back", 5'd2, 5'd2, 1'b1, 5'd2, 1'b0, 5'd0);
    drive("R2_a_only", 5'd2, 5'd5, 1'b1, 5'd2, 1'b0, 5'd0);
    drive("R3_two_apart", 5'd2, 5'd2, 1'b1, 5'd9, 1'b1, 5'd2);
    drive("R4_both_stages", 5'd6, 5'd6, 1'b1, 5'd6, 1'b1, 5'd6);
    drive("R5_zero_both", 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
    drive("R5_zero_exm_mwb_ok", 5'd0, 5'd11, 1'b1, 5'd0, 1'b1, 5'd11);
    drive("R6_exm_off", 5'd12, 5'd12, 1'b0, 5'd12, 1'b0, 5'd3);
    drive("R6_exm_off_mwb_on", 5'd12, 5'd12, 1'b0, 5'd12, 1'b1, 5'd12);
    drive("R7_split", 5'd13, 5'd14, 1'b1, 5'd13, 1'b1, 5'd14);
    drive("R7_split_swap", 5'd14, 5'd13, 1'b1, 5'd13, 1'b1, 5'd14);
    drive("R5_wr0_src_a0", 5'd0, 5'd31, 1'b1, 5'd0, 1'b1, 5'd31);
    for (int i = 0; i < 300; i++) begin
      drive("R9_random", 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            1'($urandom), 5'($urandom_range(0, 3)),
            1'($urandom), 5'($urandom_range(0, 3)));
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule